// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block forms the read side of a byte-wide nonvolatile memory model. While no self-timed program cycle is running, a read access returns the byte fetched from the array. A read access means chip select low, output enable low and write strobe high. While a program cycle runs, every read access returns a status byte instead. The host can poll that byte to learn when programming has finished, so no separate ready pin is needed.

The status byte carries two completion indicators. The top bit is the inverse of the top bit of the byte most recently written. The bit below it flips at each new read access. The remaining low bits repeat the last written byte. The write controller supplies the busy flag and the last written byte. The array supplies the read byte. The block does not model a bidirectional pin. It presents the byte to drive and a drive-enable flag, and returns zero on the data output whenever it does not drive.

Top module: `eow_status_rd`

## Requirements
- R1: Reset is asynchronous and active low. It clears the access-toggle state, so the first read access that sees busy high after reset returns 1 on data bit 6 (bit DW-2).
- R2: With busy low, a read access (ce_n=0, oe_n=0, we_n=1) drives dq_drv=1 and returns arr_rd on all bits in the same cycle.
- R3: If ce_n=1, oe_n=1 or we_n=0, then dq_drv=0 and dq_out=0.
- R4: With busy high, read data bit 7 (bit DW-1) is the complement of bit 7 of last_wr.
- R5: With busy high, data bit 6 takes the opposite value at each new read access. A new access starts in the first cycle in which the read condition holds after a cycle in which it did not.
- R6: Data bit 6 holds one value for the whole of a single read access that lasts several cycles while busy stays high.
- R7: With busy high, data bits 5..0 equal bits 5..0 of last_wr.
- R8: With busy low, reads return true array data on every bit and the toggle state stays frozen. The next read access during a later busy period returns the opposite of the last bit 6 value seen.
- R9: Polling may start at any point. If busy rises during a read access already in progress, the status byte appears in that same cycle without a new access, and bit 6 shows the held toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| busy | input | 1 | Self-timed program cycle running |
| last_wr | input | DW | Last byte accepted by the write controller |
| arr_rd | input | DW | Byte read from the array at the current address |
| dq_out | output | DW | Byte to drive on the data bus |
| dq_drv | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with its default width DW=8. At that width the polled bit is bit 7 and the toggling bit is bit 6, which is where a host looks for them. With this width, the bench can apply last-written and array bytes that differ in every bit position, so a wrong field source or a wrong inversion shows up in at least one bit. Single-cycle, multi-cycle and back-to-back accesses, together with a busy edge in the middle of an access, cover every way the access-start detection can fire or stay silent.

// File: rtl/eow_status_rd.sv
module eow_status_rd #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          busy,
  input  logic [DW-1:0] last_wr,
  input  logic [DW-1:0] arr_rd,
  output logic [DW-1:0] dq_out,
  output logic          dq_drv
);
  localparam int PB = DW - 1;
  localparam int TB = DW - 2;

  logic rd_prev, tog, ran;
  logic rd_en, rd_start, tog_now;
  logic [DW-1:0] status;

  assign rd_en    = ~ce_n & ~oe_n & we_n;
  assign rd_start = rd_en & ~rd_prev;
  assign tog_now  = tog ^ (rd_start & busy);

  always_comb begin
    status     = last_wr;
    status[PB] = ~last_wr[PB];
    status[TB] = tog_now;
  end

  assign dq_drv = rd_en;
  assign dq_out = rd_en ? (busy ? status : arr_rd) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      tog     <= 1'b0;
      ran     <= 1'b0;
    end else begin
      rd_prev <= rd_en;
      tog     <= tog_now;
      ran     <= 1'b1;
    end
  end

  p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (!dq_drv && dq_out == '0));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ce_n && !oe_n && we_n) |-> (dq_drv && dq_out == arr_rd));

  p_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_drv) |-> (dq_out[PB] != last_wr[PB]));

  p_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_drv) |-> (dq_out[TB-1:0] == last_wr[TB-1:0]));

  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_drv && !rd_prev) |-> (dq_out[TB] != tog));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && busy && $past(busy) && dq_drv && $past(dq_drv)) |-> $stable(dq_out[TB]));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && !$past(busy)) |-> $stable(tog));
endmodule

// File: tb/eow_status_rd_test.sv
module eow_status_rd_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_wr = 8'h00, arr_rd = 8'h00;
  logic [7:0] dq_out;
  logic dq_drv;
  int total = 0, bad = 0;
  int m_acc = 0;
  bit m_prev = 1'b0;
  bit running = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  eow_status_rd #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .last_wr(last_wr), .arr_rd(arr_rd),
    .dq_out(dq_out), .dq_drv(dq_drv)
  );

  function automatic bit is_read();
    return (ce_n == 1'b0) && (oe_n == 1'b0) && (we_n == 1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc  = 0;
      m_prev = 1'b0;
    end else begin
      if (is_read() && !m_prev && busy) m_acc++;
      m_prev = is_read();
    end
  end

  always @(negedge clk) begin
    if (running) begin
      int acc;
      bit prv;
      logic [7:0] exp_d;
      bit exp_e;
      acc = rst_n ? m_acc : 0;
      prv = rst_n ? m_prev : 1'b0;
      exp_e = is_read();
      if (!exp_e) exp_d = 8'h00;
      else if (!busy) exp_d = arr_rd;
      else begin
        if (!prv) acc++;
        exp_d = {~last_wr[7], (acc % 2 == 1), last_wr[5:0]};
      end
      total++;
      if (dq_drv !== exp_e || dq_out !== exp_d) begin
        bad++;
        $display("FAIL %s t=%0t drv=%b data=%02h expected drv=%b data=%02h",
                 tag, $time, dq_drv, dq_out, exp_e, exp_d);
      end
    end
  end

  task automatic step(input bit c, input bit o, input bit w, input bit b,
                      input logic [7:0] lw, input logic [7:0] ar, input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      ce_n = c; oe_n = o; we_n = w; busy = b; last_wr = lw; arr_rd = ar;
    end
  endtask

  task automatic direct_b6(input bit e, input string t);
    @(negedge clk);
    #1;
    total++;
    if (dq_out[6] !== e) begin
      bad++;
      $display("FAIL %s bit6=%b expected %b", t, dq_out[6], e);
    end
  endtask

  initial begin
    running = 1'b1;
    tag = "R1";
    step(1, 1, 1, 0, 8'h00, 8'h00, 3);
    @(posedge clk); #1 rst_n = 1'b1;
    tag = "R2";
    step(0, 0, 1, 0, 8'h00, 8'h3C, 2);
    step(0, 0, 1, 0, 8'h00, 8'hC3, 1);
    step(0, 0, 1, 0, 8'hFF, 8'h00, 1);
    step(0, 0, 1, 0, 8'h00, 8'hFF, 1);
    tag = "R3";
    step(1, 0, 1, 0, 8'h11, 8'hAA, 2);
    step(0, 1, 1, 1, 8'h11, 8'hAA, 2);
    step(0, 0, 0, 1, 8'h11, 8'hAA, 2);
    step(1, 1, 0, 1, 8'h11, 8'hAA, 1);
    tag = "R1";
    step(0, 0, 1, 1, 8'hA5, 8'h5A, 1);
    direct_b6(1'b1, "R1");
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 1, 1, 8'hA5, 8'h5A, 1);
      step(0, 0, 1, 1, 8'hA5, 8'h5A, 1 + (i % 2));
    end
    tag = "R4";
    step(1, 1, 1, 1, 8'h3C, 8'hC3, 1);
    step(0, 0, 1, 1, 8'h3C, 8'hC3, 2);
    tag = "R7";
    step(0, 1, 1, 1, 8'h6B, 8'h94, 1);
    step(0, 0, 1, 1, 8'h6B, 8'h94, 1);
    step(1, 0, 1, 1, 8'hD2, 8'h2D, 1);
    step(0, 0, 1, 1, 8'hD2, 8'h2D, 1);
    tag = "R6";
    step(1, 1, 1, 1, 8'h80, 8'h7F, 1);
    step(0, 0, 1, 1, 8'h80, 8'h7F, 5);
    tag = "R8";
    step(0, 0, 1, 0, 8'h80, 8'h7E, 2);
    step(1, 1, 1, 0, 8'h80, 8'h7E, 1);
    step(0, 0, 1, 0, 8'h80, 8'h81, 2);
    step(1, 1, 1, 0, 8'h80, 8'h81, 1);
    step(0, 0, 1, 1, 8'h80, 8'h81, 2);
    tag = "R9";
    step(1, 1, 1, 0, 8'h4E, 8'hB1, 1);
    step(0, 0, 1, 0, 8'h4E, 8'hB1, 2);
    step(0, 0, 1, 1, 8'h4E, 8'hB1, 3);
    step(1, 1, 1, 1, 8'h4E, 8'hB1, 1);
    step(0, 0, 1, 1, 8'h4E, 8'hB1, 1);
    tag = "R1";
    step(1, 1, 1, 1, 8'h4E, 8'hB1, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    step(1, 1, 1, 1, 8'h4E, 8'hB1, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    step(0, 0, 1, 1, 8'hE7, 8'h18, 1);
    direct_b6(1'b1, "R1");
    step(1, 1, 1, 0, 8'hE7, 8'h18, 2);
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule